// File: doc/BRIEF.md
# Aliased-Field General Register File

This block holds eight 32-bit general registers behind two combinational read ports and one clocked write port. Every access names a register index and an access width. The width can be a full doubleword, the low half-word, or a single byte. Narrow accesses are not separate storage. They are fixed windows into the wide registers. A narrow write therefore merges its field into the word already stored and keeps every bit outside the window.

Byte access reaches only registers 0 to 3. In byte mode the 3-bit index picks a window as follows: codes 0 to 3 select bits 7:0 of registers 0 to 3, and codes 4 to 7 select bits 15:8 of registers 0 to 3 (code minus four). Reads return the selected field zero-extended to 32 bits. A read always shows the contents from before the clock edge, so a read and a write that target the same register in one cycle return the old value.

Top module: `gpr_alias_rf`

## Requirements
- R1: After reset, all eight registers hold zero, so every read at every legal width returns 0.
- R2: A write with size code 2'b10 replaces all 32 bits of register `wr_idx` (0 to 7). A read with size 2'b10 returns the whole register.
- R3: A write with size code 2'b01 changes only bits 15:0 and keeps bits 31:16. A read with 2'b01 returns bits 15:0 in data[15:0], with zeros above.
- R4: A write with size code 2'b00 and index 0 to 3 changes only bits 7:0 of that register. A read of the same window returns those bits in data[7:0], with zeros above.
- R5: A write with size code 2'b00 and index 4 to 7 changes only bits 15:8 of register (index−4), taking them from wr_data[7:0]. A read of the same window returns bits 15:8 in data[7:0], with zeros above.
- R6: A write changes no register other than the one addressed. While `wr_en` is low, no register changes.
- R7: A write with size code 2'b11 changes nothing. A read with size code 2'b11 returns 0.
- R8: A read issued in the same cycle as a write to the same register returns the value from before that write.
- R9: The two read ports are independent. Each port returns its own index and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register or byte-window index |
| wr_size | input | 2 | Write width: 00 byte, 01 half-word, 10 word, 11 illegal |
| wr_data | input | 32 | Write data; narrow writes take their field from the low bits |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 width |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 width |
| rd1_data | output | 32 | Read port 1 data, zero-extended |

## Verification
The assertions expect the write controls to be known and stable at each rising edge. They also expect a byte-mode index of 4 or above to stand for a high-byte window and not for a fifth register. The stimulus changes every input only on the falling edge, so no input moves near the active edge. It draws indices and sizes over their full ranges, including the illegal size code, so each assertion sees both its triggering and its non-triggering cases.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_BAD   = 2'b11
  } gpr_size_e;
endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NREG      = 8,
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BYTE_REGS = 4,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  gpr_size_e                   size_i,
  output logic [DATA_W-1:0]           data_o
);
  localparam logic [IDX_W-1:0] BOFS = IDX_W'(BYTE_REGS);

  // Pick the register and field window, then zero-extend.
  always_comb begin
    data_o = '0;
    unique case (size_i)
      SZ_WORD: data_o = regs_i[idx_i];
      SZ_HALF: data_o[HALF_W-1:0] = regs_i[idx_i][HALF_W-1:0];
      SZ_BYTE: begin
        if (idx_i < BOFS)
          data_o[BYTE_W-1:0] = regs_i[idx_i][BYTE_W-1:0];
        else
          data_o[BYTE_W-1:0] = regs_i[idx_i - BOFS][2*BYTE_W-1:BYTE_W];
      end
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NREG      = 8,
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BYTE_REGS = 4,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  gpr_size_e                   wr_size_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [NREG-1:0]             we_o,
  output logic [NREG-1:0][DATA_W-1:0] nxt_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [IDX_W-1:0] LO_CODE = IDX_W'(r);
    if (r < BYTE_REGS) begin : g_bytes
      // Registers with byte windows decode both the low and the high code.
      localparam logic [IDX_W-1:0] HI_CODE = IDX_W'(r + BYTE_REGS);
      always_comb begin
        we_o[r]  = 1'b0;
        nxt_o[r] = regs_i[r];
        if (wr_en_i) begin
          unique case (wr_size_i)
            SZ_WORD: if (wr_idx_i == LO_CODE) begin
              we_o[r]  = 1'b1;
              nxt_o[r] = wr_data_i;
            end
            SZ_HALF: if (wr_idx_i == LO_CODE) begin
              we_o[r] = 1'b1;
              nxt_o[r][HALF_W-1:0] = wr_data_i[HALF_W-1:0];
            end
            SZ_BYTE: begin
              if (wr_idx_i == LO_CODE) begin
                we_o[r] = 1'b1;
                nxt_o[r][BYTE_W-1:0] = wr_data_i[BYTE_W-1:0];
              end else if (wr_idx_i == HI_CODE) begin
                we_o[r] = 1'b1;
                nxt_o[r][2*BYTE_W-1:BYTE_W] = wr_data_i[BYTE_W-1:0];
              end
            end
            default: ;
          endcase
        end
      end
    end else begin : g_nobytes
      always_comb begin
        we_o[r]  = 1'b0;
        nxt_o[r] = regs_i[r];
        if (wr_en_i && wr_idx_i == LO_CODE) begin
          unique case (wr_size_i)
            SZ_WORD: begin
              we_o[r]  = 1'b1;
              nxt_o[r] = wr_data_i;
            end
            SZ_HALF: begin
              we_o[r] = 1'b1;
              nxt_o[r][HALF_W-1:0] = wr_data_i[HALF_W-1:0];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             we_i,
  input  logic [NREG-1:0][DATA_W-1:0] nxt_i,
  output logic [NREG-1:0][DATA_W-1:0] q_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o[r] <= '0;
      else if (we_i[r]) q_o[r] <= nxt_i[r];
    end
  end
endmodule

// File: rtl/gpr_alias_rf.sv
module gpr_alias_rf
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NREG      = 8,
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BYTE_REGS = 4,
  localparam int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data
);
  localparam logic [IDX_W-1:0] BOFS = IDX_W'(BYTE_REGS);

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [NREG-1:0][DATA_W-1:0] nxt;
  logic [NREG-1:0]             we;

  gpr_write_merge #(
    .DATA_W(DATA_W), .NREG(NREG), .HALF_W(HALF_W),
    .BYTE_W(BYTE_W), .BYTE_REGS(BYTE_REGS)
  ) u_merge (
    .regs_i(regs), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_size_i(gpr_size_e'(wr_size)), .wr_data_i(wr_data),
    .we_o(we), .nxt_o(nxt)
  );

  gpr_storage #(.DATA_W(DATA_W), .NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(we), .nxt_i(nxt), .q_o(regs)
  );

  gpr_read_port #(
    .DATA_W(DATA_W), .NREG(NREG), .HALF_W(HALF_W),
    .BYTE_W(BYTE_W), .BYTE_REGS(BYTE_REGS)
  ) u_rd0 (
    .regs_i(regs), .idx_i(rd0_idx), .size_i(gpr_size_e'(rd0_size)), .data_o(rd0_data)
  );

  gpr_read_port #(
    .DATA_W(DATA_W), .NREG(NREG), .HALF_W(HALF_W),
    .BYTE_W(BYTE_W), .BYTE_REGS(BYTE_REGS)
  ) u_rd1 (
    .regs_i(regs), .idx_i(rd1_idx), .size_i(gpr_size_e'(rd1_size)), .data_o(rd1_data)
  );

  // Storage must not move without an enabled, legal write.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
  p_bad_size_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b11) |=> $stable(regs));
  // Merge on write keeps the bits outside the window.
  p_half_keeps_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b01) |=>
      regs[$past(wr_idx)][DATA_W-1:HALF_W] == $past(regs[wr_idx][DATA_W-1:HALF_W]));
  p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b10) |=> regs[$past(wr_idx)] == $past(wr_data));
  p_low_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00 && wr_idx < BOFS) |=>
      regs[$past(wr_idx)] == {$past(regs[wr_idx][DATA_W-1:BYTE_W]), $past(wr_data[BYTE_W-1:0])});
  p_high_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00 && wr_idx >= BOFS) |=>
      (regs[$past(wr_idx) - BOFS][2*BYTE_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0])) &&
      (regs[$past(wr_idx) - BOFS][BYTE_W-1:0] == $past(regs[wr_idx - BOFS][BYTE_W-1:0])));
  // Read side: illegal width yields zero, full width mirrors storage.
  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == 2'b11) |-> rd0_data == '0);
  p_full_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_size == 2'b10) |-> rd1_data == regs[rd1_idx]);
endmodule

// File: tb/gpr_alias_rf_tb.sv
module gpr_alias_rf_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic [31:0] rd0_data, rd1_data;

  logic [31:0] model [8];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpr_alias_rf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data)
  );

  function automatic logic [31:0] exp_rd(logic [2:0] idx, logic [1:0] sz);
    case (sz)
      2'b10: return model[idx];
      2'b01: return {16'h0, model[idx][15:0]};
      2'b00: return (idx < 3'd4) ? {24'h0, model[idx][7:0]}
                                 : {24'h0, model[idx - 3'd4][15:8]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void apply_model(logic [2:0] idx, logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'b10: model[idx] = d;
      2'b01: model[idx][15:0] = d[15:0];
      2'b00: if (idx < 3'd4) model[idx][7:0] = d[7:0];
             else model[idx - 3'd4][15:8] = d[7:0];
      default: ;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Both ports read at once, checked shortly after the falling edge.
  task automatic read2(string req, logic [2:0] i0, logic [1:0] s0,
                       logic [2:0] i1, logic [1:0] s1);
    @(negedge clk);
    rd0_idx = i0; rd0_size = s0; rd1_idx = i1; rd1_size = s1;
    #1;
    check(req, rd0_data, exp_rd(i0, s0));
    check(req, rd1_data, exp_rd(i1, s1));
  endtask

  task automatic write(logic [2:0] idx, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    apply_model(idx, sz, d);
  endtask

  initial begin
    wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
    rd0_idx = 0; rd0_size = 2'b10; rd1_idx = 0; rd1_size = 2'b10;
    rst_n = 0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: everything reads zero after reset
    for (int i = 0; i < 8; i++) read2("R1", 3'(i), 2'b10, 3'(i), 2'b00);

    // R2: full-word write and read
    write(3'd3, 2'b10, 32'h11223344);
    read2("R2", 3'd3, 2'b10, 3'd7, 2'b10);
    // R3: half-word merge keeps upper
    write(3'd3, 2'b01, 32'hFFFFAAAA);
    read2("R3", 3'd3, 2'b10, 3'd3, 2'b01);
    check("R3", rd0_data, 32'h1122AAAA);
    // R4: low byte merge
    write(3'd3, 2'b00, 32'hFFFFFF55);
    read2("R4", 3'd3, 2'b10, 3'd3, 2'b00);
    check("R4", rd0_data, 32'h1122AA55);
    // R5: high byte of register 3 through code 7
    write(3'd7, 2'b00, 32'hFFFFFF66);
    read2("R5", 3'd3, 2'b10, 3'd7, 2'b00);
    check("R5", rd0_data, 32'h11226655);
    check("R5", rd1_data, 32'h00000066);
    // R7: illegal size write ignored and illegal read returns zero
    write(3'd3, 2'b11, 32'hDEADBEEF);
    read2("R7", 3'd3, 2'b10, 3'd3, 2'b11);
    check("R7", rd1_data, 32'h0);
    // R6: disabled write leaves storage alone; other registers untouched
    @(negedge clk);
    wr_idx = 3'd3; wr_size = 2'b10; wr_data = 32'hCAFEF00D;
    @(negedge clk);
    read2("R6", 3'd3, 2'b10, 3'd2, 2'b10);
    check("R6", rd0_data, 32'h11226655);
    // R8: same-cycle read sees old value, new value afterwards
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd3; wr_size = 2'b10; wr_data = 32'h0BADF00D;
    rd0_idx = 3'd3; rd0_size = 2'b10;
    #1;
    check("R8", rd0_data, 32'h11226655);
    @(negedge clk);
    wr_en = 1'b0;
    apply_model(3'd3, 2'b10, 32'h0BADF00D);
    #1;
    check("R8", rd0_data, 32'h0BADF00D);
    // R9: ports read different registers at different widths
    write(3'd5, 2'b10, 32'h89ABCDEF);
    read2("R9", 3'd5, 2'b01, 3'd3, 2'b10);

    // Random mix against the reference model
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      write(3'($urandom_range(0, 7)), sz, $urandom());
      read2("R2-R5 random (R6)", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
            3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
    end
    for (int i = 0; i < 8; i++) read2("R6", 3'(i), 2'b10, 3'(i), 2'b01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule